// File: doc/BRIEF.md
# I2C Slave Address-Match and ACK Responder

This block is the receive half of an I2C slave byte engine. It watches SCL and SDA after both have been synchronized to the system clock. It detects START and STOP conditions and shifts in eight bits, MSB first, on rising SCL edges. Once a byte is complete, it decides whether to pull SDA low during the ninth (acknowledge) clock. The first byte after a START is the address byte: bits 7:1 hold the 7-bit address and bit 0 holds the read/write flag. That address is compared against up to three programmed slave addresses, and the general-call address is also recognized.

Four software controls shape the response:
- A NACK-forcing bit.
- An address-free mode, which answers address bytes without comparing them.
- A multi-address enable, which widens the comparison from slot 0 to all three slots.
- An acknowledge-clock enable.

When the acknowledge clock is off, no ninth clock is expected. The byte interrupt then fires at the falling edge that ends bit 8, and the next byte starts at once.

The enclosing controller drives the open-drain pad from `sda_pull_o`. It reads `rx_byte_o` and `addr_match_o` when `irq_o` pulses.

Top module: `i2c_ack_responder`

## Requirements
- R1: Bits are captured MSB first on rising SCL edges after a START. `rx_byte_o` is loaded at the falling SCL edge that ends bit 8. In the first byte, bits 7:1 are the address and bit 0 is read/write.
- R2: For an address byte with address-free mode off and the ACK bit 0, the responder gives ACK when the address equals slot 0.
- R3: With multi-address off, only slot 0 is compared, so a match on slot 1 or slot 2 alone gives NACK. With multi-address on, a match on any of slots 0 to 2 gives ACK.
- R4: For an address byte with address-free mode off and the ACK bit 0, the address 0000000 gives ACK. Any other address that matches no enabled slot gives NACK.
- R5: When the ACK bit is 1, the response is always NACK, for address bytes and data bytes alike.
- R6: With address-free mode on, an address byte gets ACK when the ACK bit is 0 and NACK when it is 1, whatever the address.
- R7: Every byte after the address byte is answered from the ACK bit alone: 0 gives ACK and 1 gives NACK.
- R8: The SDA pull-down is asserted after the falling SCL edge that ends bit 8. It is released after the falling edge that ends the acknowledge clock.
- R9: With the acknowledge-clock enable at 0, SDA is never pulled. `irq_o` pulses after the falling edge that ends bit 8, and the next rising edge starts a new byte.
- R10: With the acknowledge clock on, `irq_o` pulses for exactly one cycle after the falling edge that ends the acknowledge clock.
- R11: A change of the acknowledge-clock enable takes effect only while no byte is in progress. A change during a byte is held off until the byte ends, including a change on the cycle the byte completes.
- R12: A START or STOP at any point clears the bit counter, releases SDA and returns the engine to address reception. After a STOP, bits are ignored until the next START.
- R13: `addr_match_o` reflects whether the last address byte matched an enabled programmed slot; a general call does not set it. A START or STOP clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA bus level |
| ack_bit_i | input | 1 | 0: acknowledge allowed, 1: always NACK |
| addr_free_i | input | 1 | 1: answer address bytes without comparison |
| multi_addr_i | input | 1 | 1: compare against all address slots |
| ack_clk_en_i | input | 1 | 1: a ninth acknowledge clock follows each byte |
| own_addr_i | input | NUM_ADDR*ADDR_W (21) | Programmed addresses, slot k at bits k*7 +: 7 |
| sda_pull_o | output | 1 | 1: pull SDA low |
| rx_byte_o | output | ADDR_W+1 (8) | Last complete received byte |
| addr_match_o | output | 1 | Last address byte matched an enabled slot |
| irq_o | output | 1 | One-cycle byte-complete pulse |

## Verification
Two events can land in the same clock cycle: completion of a byte in no-acknowledge-clock mode, and a software change of the acknowledge-clock enable. The bench drives the enable high on the same clock edge at which the bit-8 falling edge is sampled. The finishing byte must still take the old path: an interrupt and no SDA pull. The following byte must then get a ninth clock with SDA pulled. The bench also checks the opposite case. It drops the enable in the middle of a byte, and that byte must keep its acknowledge slot.

// File: rtl/i2c_ack_pkg.sv
package i2c_ack_pkg;
   // Bus events decoded from one clock of synchronized SCL/SDA history
   typedef struct packed {
      logic scl_rise;
      logic scl_fall;
      logic start;
      logic stop;
   } bus_evt_t;
endpackage

// File: rtl/i2c_bus_events.sv
module i2c_bus_events
   import i2c_ack_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_i,
   input  logic     sda_i,
   output bus_evt_t evt_o
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   always_comb begin
      evt_o.scl_rise = scl_i & ~scl_q;
      evt_o.scl_fall = ~scl_i & scl_q;
      // SDA edges while SCL stays high mark bus conditions
      evt_o.start    = scl_i & scl_q & sda_q & ~sda_i;
      evt_o.stop     = scl_i & scl_q & ~sda_q & sda_i;
   end
endmodule

// File: rtl/i2c_ack_policy.sv
module i2c_ack_policy #(
   parameter int ADDR_W   = 7,
   parameter int NUM_ADDR = 3,
   localparam int BYTE_W  = ADDR_W + 1
) (
   input  logic [BYTE_W-1:0]          byte_i,
   input  logic                       is_addr_i,
   input  logic [NUM_ADDR*ADDR_W-1:0] slots_i,
   input  logic                       multi_i,
   input  logic                       addr_free_i,
   input  logic                       ack_bit_i,
   output logic                       hit_o,
   output logic                       ack_o
);
   logic [ADDR_W-1:0]   addr;
   logic [NUM_ADDR-1:0] slot_hit;
   logic                gcall;

   assign addr  = byte_i[BYTE_W-1:1];
   assign gcall = (addr == '0);

   for (genvar g = 0; g < NUM_ADDR; g++) begin : g_slot
      if (g == 0) begin : g_base
         assign slot_hit[g] = (addr == slots_i[g*ADDR_W +: ADDR_W]);
      end else begin : g_extra
         assign slot_hit[g] = multi_i && (addr == slots_i[g*ADDR_W +: ADDR_W]);
      end
   end

   assign hit_o = |slot_hit;

   // Data bytes follow ack_bit_i alone; address bytes also need a hit,
   // a general call, or address-free mode
   assign ack_o = !ack_bit_i && (!is_addr_i || addr_free_i || hit_o || gcall);

   always_comb begin
      if (ack_bit_i === 1'b1)
         a_r5_forced_nack: assert (!ack_o);
   end
endmodule

// File: rtl/i2c_rx_sequencer.sv
module i2c_rx_sequencer
   import i2c_ack_pkg::*;
#(
   parameter int BYTE_W = 8,
   localparam int CNT_W = $clog2(BYTE_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bus_evt_t          evt_i,
   input  logic              sda_i,
   input  logic              ack_clk_en_i,
   input  logic              ack_level_i,
   input  logic              hit_i,
   output logic [BYTE_W-1:0] shreg_o,
   output logic              is_addr_o,
   output logic              sda_pull_o,
   output logic [BYTE_W-1:0] rx_byte_o,
   output logic              addr_match_o,
   output logic              irq_o
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

   logic [CNT_W-1:0] bit_cnt;
   logic             in_ack, active_q, ackclk_q;
   logic             idle, last_fall;

   assign idle      = (bit_cnt == '0) && !in_ack;
   assign last_fall = evt_i.scl_fall && (bit_cnt == LAST) && !in_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt      <= '0;
         in_ack       <= 1'b0;
         active_q     <= 1'b0;
         ackclk_q     <= 1'b0;
         shreg_o      <= '0;
         is_addr_o    <= 1'b1;
         sda_pull_o   <= 1'b0;
         rx_byte_o    <= '0;
         addr_match_o <= 1'b0;
         irq_o        <= 1'b0;
      end else begin
         irq_o <= 1'b0;
         if (idle) ackclk_q <= ack_clk_en_i;
         if (evt_i.start || evt_i.stop) begin
            bit_cnt      <= '0;
            in_ack       <= 1'b0;
            sda_pull_o   <= 1'b0;
            is_addr_o    <= 1'b1;
            active_q     <= evt_i.start;
            addr_match_o <= 1'b0;
         end else if (active_q) begin
            if (evt_i.scl_rise && !in_ack && bit_cnt != LAST) begin
               shreg_o <= {shreg_o[BYTE_W-2:0], sda_i};
               bit_cnt <= bit_cnt + 1'b1;
            end
            if (last_fall) begin
               rx_byte_o <= shreg_o;
               if (is_addr_o) addr_match_o <= hit_i;
               if (ackclk_q) begin
                  in_ack     <= 1'b1;
                  sda_pull_o <= ack_level_i;
               end else begin
                  irq_o     <= 1'b1;
                  bit_cnt   <= '0;
                  is_addr_o <= 1'b0;
               end
            end else if (evt_i.scl_fall && in_ack) begin
               in_ack     <= 1'b0;
               sda_pull_o <= 1'b0;
               irq_o      <= 1'b1;
               bit_cnt    <= '0;
               is_addr_o  <= 1'b0;
            end
         end
      end
   end

   a_r8_pull_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull_o) |-> $past(evt_i.scl_fall));
   a_r8_release_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_pull_o) |-> $past(evt_i.scl_fall || evt_i.start || evt_i.stop));
   a_r9_no_pull_without_clk: assert property (@(posedge clk) disable iff (!rst_n)
      sda_pull_o |-> ackclk_q);
   a_r10_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);
   a_r11_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
      !idle |=> $stable(ackclk_q));
   a_r12_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i.stop |=> (!addr_match_o && !sda_pull_o));
endmodule

// File: rtl/i2c_ack_responder.sv
module i2c_ack_responder
   import i2c_ack_pkg::*;
#(
   parameter int ADDR_W   = 7,
   parameter int NUM_ADDR = 3,
   localparam int BYTE_W  = ADDR_W + 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       scl_i,
   input  logic                       sda_i,
   input  logic                       ack_bit_i,
   input  logic                       addr_free_i,
   input  logic                       multi_addr_i,
   input  logic                       ack_clk_en_i,
   input  logic [NUM_ADDR*ADDR_W-1:0] own_addr_i,
   output logic                       sda_pull_o,
   output logic [BYTE_W-1:0]          rx_byte_o,
   output logic                       addr_match_o,
   output logic                       irq_o
);
   if (ADDR_W < 1 || NUM_ADDR < 1) begin : g_bad_param
      $error("i2c_ack_responder: ADDR_W and NUM_ADDR must be at least 1");
   end

   bus_evt_t          evt;
   logic [BYTE_W-1:0] shreg;
   logic              is_addr, hit, ack_level;

   i2c_bus_events u_events (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_i (scl_i),
      .sda_i (sda_i),
      .evt_o (evt)
   );

   i2c_ack_policy #(.ADDR_W(ADDR_W), .NUM_ADDR(NUM_ADDR)) u_policy (
      .byte_i      (shreg),
      .is_addr_i   (is_addr),
      .slots_i     (own_addr_i),
      .multi_i     (multi_addr_i),
      .addr_free_i (addr_free_i),
      .ack_bit_i   (ack_bit_i),
      .hit_o       (hit),
      .ack_o       (ack_level)
   );

   i2c_rx_sequencer #(.BYTE_W(BYTE_W)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .evt_i        (evt),
      .sda_i        (sda_i),
      .ack_clk_en_i (ack_clk_en_i),
      .ack_level_i  (ack_level),
      .hit_i        (hit),
      .shreg_o      (shreg),
      .is_addr_o    (is_addr),
      .sda_pull_o   (sda_pull_o),
      .rx_byte_o    (rx_byte_o),
      .addr_match_o (addr_match_o),
      .irq_o        (irq_o)
   );
endmodule

// File: tb/i2c_ack_responder_bench.sv
module i2c_ack_responder_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl = 1'b1;
   logic        sda_drv = 1'b1;
   logic        ack_bit = 1'b0;
   logic        addr_free = 1'b0;
   logic        multi = 1'b0;
   logic        ack_clk_en = 1'b1;
   logic [20:0] own_addr = {7'h51, 7'h33, 7'h2A};
   logic        sda_pull, addr_match, irq;
   logic [7:0]  rx_byte;
   logic        sda_bus;
   int          checks = 0, errors = 0, irq_cnt = 0;
   bit          done = 0;

   assign sda_bus = sda_drv & ~sda_pull;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(negedge clk) if (irq) irq_cnt++;

   i2c_ack_responder u_i2c_ack_responder (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
      .ack_bit_i(ack_bit), .addr_free_i(addr_free), .multi_addr_i(multi),
      .ack_clk_en_i(ack_clk_en), .own_addr_i(own_addr),
      .sda_pull_o(sda_pull), .rx_byte_o(rx_byte),
      .addr_match_o(addr_match), .irq_o(irq)
   );

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic start_c();
      sda_drv = 1'b1; wt(2); scl = 1'b1; wt(3); sda_drv = 1'b0; wt(3); scl = 1'b0; wt(3);
   endtask

   task automatic stop_c();
      scl = 1'b0; wt(2); sda_drv = 1'b0; wt(2); scl = 1'b1; wt(3); sda_drv = 1'b1; wt(3);
   endtask

   task automatic bit1(input logic b);
      sda_drv = b; wt(2); scl = 1'b1; wt(4); scl = 1'b0; wt(2);
   endtask

   task automatic send8(input logic [7:0] v);
      for (int i = 7; i >= 0; i--) bit1(v[i]);
   endtask

   // ninth clock: returns whether SDA was held low while SCL was high
   task automatic ack_slot(output logic seen);
      sda_drv = 1'b1; wt(2); scl = 1'b1; wt(2); seen = sda_pull; wt(2); scl = 1'b0; wt(2);
   endtask

   task automatic byte_ack(input string tag, input logic [7:0] v, input logic exp_ack);
      logic seen;
      send8(v);
      ack_slot(seen);
      chk(tag, seen, exp_ack);
   endtask

   task automatic t_reset();
      chk("R12 reset pull", sda_pull, 0);
      chk("R13 reset match", addr_match, 0);
      chk("R10 reset irq", irq_cnt, 0);
   endtask

   task automatic t_basic();
      logic seen;
      int n0;
      start_c();
      send8(8'h55);                       // address 0x2A, R/W 1
      chk("R8 pull after bit8 fall", sda_pull, 1);
      n0 = irq_cnt;
      ack_slot(seen);
      chk("R2 slot0 ack", seen, 1);
      chk("R8 released after ack clock", sda_pull, 0);
      chk("R10 irq after ack clock", irq_cnt, n0 + 1);
      chk("R1 address byte msb first", rx_byte, 8'h55);
      chk("R13 match set", addr_match, 1);
      byte_ack("R7 data ack", 8'hC3, 1);
      chk("R1 data byte", rx_byte, 8'hC3);
      ack_bit = 1'b1;
      byte_ack("R5 data nack", 8'h3C, 0);
      ack_bit = 1'b0;
      stop_c();
      chk("R12 stop clears match", addr_match, 0);
   endtask

   task automatic t_multi();
      multi = 1'b0;
      start_c(); byte_ack("R3 slot1 ignored when multi off", {7'h33, 1'b0}, 0);
      chk("R13 no match", addr_match, 0);
      multi = 1'b1;
      start_c(); byte_ack("R3 slot2 with multi on", {7'h51, 1'b0}, 1);
      chk("R13 slot2 match", addr_match, 1);
      start_c(); byte_ack("R3 slot1 with multi on", {7'h33, 1'b1}, 1);
      start_c(); byte_ack("R4 unmatched nack", {7'h7F, 1'b0}, 0);
      chk("R13 cleared by unmatched address", addr_match, 0);
      multi = 1'b0;
      start_c(); byte_ack("R4 general call ack", 8'h00, 1);
      chk("R13 general call not a match", addr_match, 0);
      stop_c();
   endtask

   task automatic t_ackbit_free();
      ack_bit = 1'b1;
      start_c(); byte_ack("R5 matched address nack", {7'h2A, 1'b0}, 0);
      addr_free = 1'b1;
      start_c(); byte_ack("R6 free mode ack bit 1", {7'h11, 1'b0}, 0);
      ack_bit = 1'b0;
      start_c(); byte_ack("R6 free mode ack bit 0", {7'h11, 1'b0}, 1);
      addr_free = 1'b0;
      stop_c();
   endtask

   task automatic t_no_ack_clk();
      int n0;
      ack_clk_en = 1'b0; wt(3);
      start_c();
      n0 = irq_cnt;
      send8({7'h2A, 1'b0});
      chk("R9 irq at bit8 fall", irq_cnt, n0 + 1);
      chk("R9 no pull", sda_pull, 0);
      send8(8'hA7);                       // next byte begins at once
      chk("R9 back-to-back byte", rx_byte, 8'hA7);
      chk("R9 irq second byte", irq_cnt, n0 + 2);
      chk("R9 no pull data", sda_pull, 0);
      stop_c();
   endtask

   task automatic t_mode_race();
      int n0;
      logic [7:0] v;
      logic seen;
      ack_clk_en = 1'b0; wt(3);
      start_c();
      n0 = irq_cnt;
      v = {7'h2A, 1'b0};
      for (int i = 7; i >= 1; i--) bit1(v[i]);
      sda_drv = v[0]; wt(2); scl = 1'b1; wt(4);
      scl = 1'b0; ack_clk_en = 1'b1;      // enable changes with the bit-8 fall
      wt(2);
      chk("R11 finishing byte keeps old mode irq", irq_cnt, n0 + 1);
      chk("R11 finishing byte no pull", sda_pull, 0);
      byte_ack("R11 next byte gets ack clock", 8'h96, 1);
      v = 8'h5A;
      for (int i = 7; i >= 4; i--) bit1(v[i]);
      ack_clk_en = 1'b0;                  // mid-byte change held off
      for (int i = 3; i >= 0; i--) bit1(v[i]);
      ack_slot(seen);
      chk("R11 mid-byte change ignored", seen, 1);
      ack_clk_en = 1'b1;
      stop_c();
   endtask

   task automatic t_abort();
      stop_c();
      bit1(1'b1); bit1(1'b0); bit1(1'b1);  // ignored after STOP
      start_c();
      bit1(1'b0); bit1(1'b1); bit1(1'b1);  // aborted by repeated START
      start_c();
      byte_ack("R12 counter reset by START", {7'h2A, 1'b1}, 1);
      chk("R12 address after restart", rx_byte, {7'h2A, 1'b1});
      stop_c();
      chk("R12 released after stop", sda_pull, 0);
   endtask

   initial begin
      wt(5);
      rst_n = 1'b1;
      wt(3);
      t_reset();
      t_basic();
      t_multi();
      t_ackbit_free();
      t_no_ack_clk();
      t_mode_race();
      t_abort();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule